// File: doc/BRIEF.md
# Signed-Magnitude Operand Comparator

This block orders two operands that are coded in signed-magnitude form and reports the result on three flags: A below B, A equal to B, and A above B. Each operand carries its sign in the most significant bit and an unsigned magnitude in the bits under it. With the default parameters the operands are 4 bits wide: a sign and a 3-bit magnitude. The operands therefore cover the values -7 to +7, and zero has two encodings.

The block has no clock and no storage. The flags follow the operands through combinational logic alone. The magnitude compare can be built in either of two forms, chosen by a parameter. One form is an explicit bit-serial chain that runs from the most significant bit down. The other form is a plain relational operator that synthesis maps. A resolver stage then folds in the two signs and the zero cases.

Top module: `sm_compare`

## Requirements
- R1: Each operand is MAG_W+1 bits wide (4 by default). Bit MAG_W (bit 3) is the sign, where 1 means negative. Bits MAG_W-1..0 (bits 2..0) hold the unsigned magnitude. For example, 4'b1001 is -1 and 4'b0001 is +1.
- R2: For every pair of operands exactly one of a_lt_b, a_eq_b and a_gt_b is high.
- R3: When both operands are non-negative, they are ordered by their magnitudes.
- R4: When the signs differ and neither magnitude is zero, the negative operand is the smaller.
- R5: When both operands are negative, the one with the larger magnitude is the smaller value.
- R6: Positive zero (4'b0000) and negative zero (4'b1000) compare as equal. Either zero is greater than any negative nonzero operand and less than any positive nonzero operand.
- R7: Two identical encodings always give a_eq_b.
- R8: The flags are a pure function of the present operands. A change of operand reaches the flags without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | MAG_W+1 | Operand A, signed-magnitude |
| op_b | input | MAG_W+1 | Operand B, signed-magnitude |
| a_lt_b | output | 1 | A is less than B |
| a_eq_b | output | 1 | A equals B |
| a_gt_b | output | 1 | A is greater than B |

## Verification
The block holds no state, so any fault is a wrong function of the operands. Such a fault shows on the flags for the affected pairs as soon as those operands are applied. A fault in the sign resolver shows only on pairs that have at least one negative operand. A fault in the zero folding shows only on pairs that involve negative zero. Because of this, the bench applies all 256 pairs and checks each pair against an integer reference, so every input region is covered.

// File: rtl/smcmp_pkg.sv
package smcmp_pkg;

   // Ordering result, one-hot by construction of the resolver
   typedef struct packed {
      logic lt;
      logic eq;
      logic gt;
   } ord_t;

   localparam int ARCH_CHAIN = 0;
   localparam int ARCH_RELOP = 1;

endpackage

// File: rtl/smcmp_magcmp.sv
module smcmp_magcmp
   import smcmp_pkg::*;
#(
   parameter int W    = 3,
   parameter int ARCH = ARCH_CHAIN
) (
   input  logic [W-1:0] mag_a,
   input  logic [W-1:0] mag_b,
   output ord_t         res
);

   generate
      if (ARCH == ARCH_CHAIN) begin : g_chain
         // Bit-serial compare, MSB first: first differing bit decides
         logic [W:0] gt_c;
         logic [W:0] eq_c;
         assign gt_c[W] = 1'b0;
         assign eq_c[W] = 1'b1;
         for (genvar i = W - 1; i >= 0; i--) begin : g_bit
            assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & mag_a[i] & ~mag_b[i]);
            assign eq_c[i] = eq_c[i+1] & ~(mag_a[i] ^ mag_b[i]);
         end
         assign res.gt = gt_c[0];
         assign res.eq = eq_c[0];
         assign res.lt = ~gt_c[0] & ~eq_c[0];
      end else begin : g_relop
         assign res.gt = (mag_a > mag_b);
         assign res.eq = (mag_a == mag_b);
         assign res.lt = (mag_a < mag_b);
      end
   endgenerate

endmodule

// File: rtl/smcmp_zero_detect.sv
module smcmp_zero_detect #(
   parameter int W = 3
) (
   input  logic [W-1:0] mag,
   output logic         is_zero
);

   assign is_zero = ~|mag;

endmodule

// File: rtl/smcmp_resolve.sv
module smcmp_resolve
   import smcmp_pkg::*;
(
   input  logic sign_a,
   input  logic sign_b,
   input  logic zero_a,
   input  logic zero_b,
   input  ord_t mag_ord,
   output ord_t res
);

   logic neg_a;
   logic neg_b;

   // A zero magnitude counts as non-negative whatever its sign bit
   assign neg_a = sign_a & ~zero_a;
   assign neg_b = sign_b & ~zero_b;

   always_comb begin
      res = mag_ord;
      unique case ({neg_a, neg_b})
         2'b10:   res = '{lt: 1'b1, eq: 1'b0, gt: 1'b0};
         2'b01:   res = '{lt: 1'b0, eq: 1'b0, gt: 1'b1};
         2'b11:   res = '{lt: mag_ord.gt, eq: mag_ord.eq, gt: mag_ord.lt};
         default: res = mag_ord;
      endcase
   end

endmodule

// File: rtl/sm_compare.sv
module sm_compare
   import smcmp_pkg::*;
#(
   parameter int MAG_W = 3,
   parameter int ARCH  = ARCH_CHAIN
) (
   input  logic [MAG_W:0] op_a,
   input  logic [MAG_W:0] op_b,
   output logic           a_lt_b,
   output logic           a_eq_b,
   output logic           a_gt_b
);

   localparam int SIGN_BIT = MAG_W;

   generate
      if (MAG_W < 1) begin : g_bad_width
         $error("sm_compare: MAG_W must be at least 1");
      end
      if (ARCH != ARCH_CHAIN && ARCH != ARCH_RELOP) begin : g_bad_arch
         $error("sm_compare: ARCH must select chain or relop");
      end
   endgenerate

   logic zero_a;
   logic zero_b;
   ord_t mag_ord;
   ord_t fin_ord;

   smcmp_zero_detect #(.W(MAG_W)) u_zero_a (
      .mag     (op_a[MAG_W-1:0]),
      .is_zero (zero_a)
   );

   smcmp_zero_detect #(.W(MAG_W)) u_zero_b (
      .mag     (op_b[MAG_W-1:0]),
      .is_zero (zero_b)
   );

   smcmp_magcmp #(.W(MAG_W), .ARCH(ARCH)) u_mag (
      .mag_a (op_a[MAG_W-1:0]),
      .mag_b (op_b[MAG_W-1:0]),
      .res   (mag_ord)
   );

   smcmp_resolve u_res (
      .sign_a  (op_a[SIGN_BIT]),
      .sign_b  (op_b[SIGN_BIT]),
      .zero_a  (zero_a),
      .zero_b  (zero_b),
      .mag_ord (mag_ord),
      .res     (fin_ord)
   );

   assign a_lt_b = fin_ord.lt;
   assign a_eq_b = fin_ord.eq;
   assign a_gt_b = fin_ord.gt;

endmodule

// File: rtl/smcmp_chk.sv
module smcmp_chk #(
   parameter int MAG_W = 3
) (
   input logic [MAG_W:0] op_a,
   input logic [MAG_W:0] op_b,
   input logic           a_lt_b,
   input logic           a_eq_b,
   input logic           a_gt_b
);

   logic [MAG_W-1:0] ma;
   logic [MAG_W-1:0] mb;
   logic             sa;
   logic             sb;
   logic             known;

   assign ma    = op_a[MAG_W-1:0];
   assign mb    = op_b[MAG_W-1:0];
   assign sa    = op_a[MAG_W];
   assign sb    = op_b[MAG_W];
   assign known = !$isunknown({op_a, op_b, a_lt_b, a_eq_b, a_gt_b});

   always_comb begin
      if (known) begin
         // R2
         one_flag_chk: assert ($countones({a_lt_b, a_eq_b, a_gt_b}) == 1);
         // R7
         same_code_eq_chk: assert (op_a != op_b || a_eq_b);
         // R6
         zero_pair_eq_chk: assert (ma != '0 || mb != '0 || a_eq_b);
         // R4
         neg_side_low_chk: assert (!(ma != '0 && mb != '0 && sa && !sb) || a_lt_b);
         // R5
         neg_big_low_chk: assert (!(sa && sb && ma > mb) || a_lt_b);
         // R3
         pos_order_chk: assert (!(!sa && !sb && ma > mb) || a_gt_b);
      end
   end

endmodule

bind sm_compare smcmp_chk #(.MAG_W(MAG_W)) u_chk (
   .op_a   (op_a),
   .op_b   (op_b),
   .a_lt_b (a_lt_b),
   .a_eq_b (a_eq_b),
   .a_gt_b (a_gt_b)
);

// File: tb/sm_compare_tb.sv
`timescale 1ns/1ps
module sm_compare_tb;

   localparam int MAG_W = 3;
   localparam int OPW   = MAG_W + 1;

   logic           clk = 1'b0;
   logic [OPW-1:0] op_a = '0;
   logic [OPW-1:0] op_b = '0;
   logic           a_lt_b;
   logic           a_eq_b;
   logic           a_gt_b;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   sm_compare #(.MAG_W(MAG_W)) u_dut (
      .op_a   (op_a),
      .op_b   (op_b),
      .a_lt_b (a_lt_b),
      .a_eq_b (a_eq_b),
      .a_gt_b (a_gt_b)
   );

   function automatic int to_int(input logic [OPW-1:0] v);
      int m;
      m = int'(v[MAG_W-1:0]);
      return v[MAG_W] ? -m : m;
   endfunction

   function automatic string req_of(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
      if (a == b) return "R7";
      if (a[MAG_W-1:0] == 0 || b[MAG_W-1:0] == 0) return "R6";
      if (a[MAG_W] != b[MAG_W]) return "R4";
      if (a[MAG_W]) return "R5";
      return "R3";
   endfunction

   task automatic check(input string req);
      int ia;
      int ib;
      logic [2:0] exp;
      logic [2:0] got;
      ia  = to_int(op_a);
      ib  = to_int(op_b);
      exp = {ia < ib, ia == ib, ia > ib};
      got = {a_lt_b, a_eq_b, a_gt_b};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s a=%b b=%b actual lt/eq/gt=%b expected=%b", req, op_a, op_b, got, exp);
      end
      n_checks++;
      if ($countones(got) != 1) begin
         n_fail++;
         $display("FAIL R2 a=%b b=%b actual flags=%b expected one-hot", op_a, op_b, got);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual cycles=%0d expected below 5000", cycles);
         finish_run();
      end
   end

   initial begin
      // Initial state: both operands zero -> equal (R6)
      @(negedge clk);
      check("R6");

      // R1: sign bit at MSB, 1001 is -1, 0001 is +1
      @(posedge clk); op_a = 4'b1001; op_b = 4'b0001;
      @(negedge clk); check("R1");

      // R6: negative zero against positive zero
      @(posedge clk); op_a = 4'b1000; op_b = 4'b0000;
      @(negedge clk); check("R6");

      // R8: change operands mid-cycle, sample 1 ns later with no edge between
      op_a = 4'b0111; op_b = 4'b1111;
      #1 check("R8");

      // Exhaustive sweep of all pairs
      for (int i = 0; i < (1 << OPW); i++) begin
         for (int j = 0; j < (1 << OPW); j++) begin
            @(posedge clk);
            op_a = OPW'(i);
            op_b = OPW'(j);
            @(negedge clk);
            check(req_of(op_a, op_b));
         end
      end

      finish_run();
   end

endmodule